// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes the data operations of a stack machine. Every instruction carries a 3-bit opcode. Only `push` and `pop` also carry a memory address. `push` reads a word from memory and places it on the stack. `pop` writes the top word to memory and removes it from the stack. The arithmetic operations (`add`, `sub`, `mult`) take no operand field. They consume the two uppermost stack entries and leave one result in their place.

The upper part of the stack lives in a small internal window of registers. When the window is full and another push arrives, the lowest window entry is first written to a reserved spill region of memory. When an operation needs an entry that has been spilled, that entry is first read back into the window. Instructions arrive over a valid/ready handshake. One memory port serves data traffic and spill traffic, and the memory returns read data one cycle after the request. Two single-cycle status pulses report stack underflow and stack overflow, and the total stack depth is visible at all times.

Top module: `stack_exec_unit`

## Requirements
- R1: Opcode 0 (push) reads the memory word at `instr_addr` and places it on top of the stack. The depth rises by one two cycles after acceptance when the window has room.
- R2: Opcode 1 (pop) writes the current top word to `instr_addr` and removes it from the stack.
- R3: Opcode 2 (add) and opcode 4 (mult) replace the two top entries with their sum or product. Only the low `W` bits are kept, and results wrap modulo 2^W. The depth never changes by more than one per cycle.
- R4: Opcode 3 (sub) replaces the two top entries with the top entry minus the entry below it, modulo 2^W.
- R5: An arithmetic instruction accepted while the window holds at least two entries completes at its accepting clock edge. It makes no memory request.
- R6: A push that finds all `DEPTH` window entries occupied first writes the lowest window entry to address `SPILL_BASE + n`, where `n` is the number of entries already spilled.
- R7: When pop or an arithmetic operation lacks window entries but spilled entries exist, the most recently spilled entry is read back below the window entries first. The stack keeps last-in, first-out order across any number of spills and refills.
- R8: An arithmetic instruction with fewer than two stack entries, or a pop on an empty stack, raises `flag_underflow` for the one cycle after acceptance. The stack depth stays unchanged and memory is not written.
- R9: A push when `DEPTH + SPILL_DEPTH` entries are held raises `flag_overflow` for the one cycle after acceptance and leaves the stack unchanged.
- R10: Opcodes 5, 6 and 7 are accepted and have no effect: no memory request, no depth change, no flag.
- R11: After reset, `instr_ready` is high, the depth is zero, both flags are low and no memory request is made.
- R12: An instruction is taken at a clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` stays low while a multi-cycle instruction is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mult, 5-7 no effect |
| instr_addr | input | AW | Memory address for push and pop |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, one cycle after a read request |
| flag_underflow | output | 1 | One-cycle pulse: instruction rejected for lack of operands |
| flag_overflow | output | 1 | One-cycle pulse: push rejected, stack full |
| stack_depth | output | TW | Entries held, window plus spill region |

## Verification
The unit is driven with several kinds of stimulus:

- An expression sequence of pushes and mixed arithmetic. It shows whether operand order and intermediate results survive a realistic instruction stream.
- Chosen operand pairs for subtraction and multiplication. These separate top-minus-second from the reverse order and show that only the low product word is kept.
- A stack driven deeper than the window and then folded back by additions. This separates correct spill and refill ordering from an off-by-one slot or a reversed refill.
- Filling to the full capacity and draining with pops. This exposes overflow handling and end-to-end last-in, first-out order.
- Random mixes of all opcodes, including empty-stack cases. These reach underflow and the no-effect opcodes from many stack states.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [2:0] OPC_PUSH = 3'd0;
  localparam logic [2:0] OPC_POP  = 3'd1;
  localparam logic [2:0] OPC_ADD  = 3'd2;
  localparam logic [2:0] OPC_SUB  = 3'd3;
  localparam logic [2:0] OPC_MUL  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RETRY,
    ST_FETCH,
    ST_LOAD,
    ST_REFILL
  } ctrl_state_e;

  typedef enum logic [2:0] {
    W_HOLD,
    W_PUSH,
    W_POP,
    W_COMBINE,
    W_DROP,
    W_APPEND
  } win_cmd_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] top,
  input  logic [W-1:0] second,
  output logic [W-1:0] res
);

  logic [2*W-1:0] prod;

  always_comb begin
    prod = top * second;
    case (op)
      OPC_SUB: res = top - second;
      OPC_MUL: res = prod[W-1:0];
      default: res = top + second;
    endcase
  end

endmodule

// File: rtl/stk_window.sv
module stk_window
  import stk_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int DEPTH = 4,
  localparam int ICW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  win_cmd_e       cmd,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   top,
  output logic [W-1:0]   second,
  output logic [W-1:0]   bottom,
  output logic [ICW-1:0] cnt
);

  logic [DEPTH-1:0][W-1:0] ent_q, ent_d, shift_up, shift_dn, appended;
  logic [ICW-1:0]          cnt_q, cnt_d;

  assign shift_up = {ent_q[DEPTH-1], ent_q[DEPTH-1:1]};
  assign shift_dn = {ent_q[DEPTH-2:0], din};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign appended[i] = (cnt_q == ICW'(i)) ? din : ent_q[i];
  end

  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    case (cmd)
      W_PUSH:    begin ent_d = shift_dn; cnt_d = cnt_q + 1'b1; end
      W_POP:     begin ent_d = shift_up; cnt_d = cnt_q - 1'b1; end
      W_COMBINE: begin ent_d = shift_up; ent_d[0] = din; cnt_d = cnt_q - 1'b1; end
      W_DROP:    cnt_d = cnt_q - 1'b1;
      W_APPEND:  begin ent_d = appended; cnt_d = cnt_q + 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cmd != W_HOLD) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign top    = ent_q[0];
  assign second = ent_q[1];
  assign bottom = ent_q[DEPTH-1];
  assign cnt    = cnt_q;

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter  int W           = 16,
  parameter  int AW          = 8,
  parameter  int DEPTH       = 4,
  parameter  int SPILL_DEPTH = 16,
  parameter  int SPILL_BASE  = 224,
  localparam int ICW         = $clog2(DEPTH + 1),
  localparam int SCW         = $clog2(SPILL_DEPTH + 1),
  localparam int TW          = $clog2(DEPTH + SPILL_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  output logic           instr_ready,
  input  logic [2:0]     instr_op,
  input  logic [AW-1:0]  instr_addr,
  input  logic [ICW-1:0] win_cnt,
  input  logic [W-1:0]   win_top,
  input  logic [W-1:0]   win_bottom,
  input  logic [W-1:0]   alu_res,
  output logic [2:0]     alu_op,
  output win_cmd_e       win_cmd,
  output logic [W-1:0]   win_din,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic           flag_underflow,
  output logic           flag_overflow,
  output logic [TW-1:0]  stack_depth
);

  ctrl_state_e    state_q, state_d;
  logic [2:0]     op_q, cur_op;
  logic [AW-1:0]  addr_q, cur_addr, spill_wr_addr, spill_rd_addr;
  logic [SCW-1:0] scnt_q, scnt_d;
  logic           unf_q, unf_d, ovf_q, ovf_d;
  logic           go, win_full, spill_full;
  logic [TW-1:0]  total;

  assign instr_ready   = (state_q == ST_IDLE);
  assign go            = (instr_ready && instr_valid) || (state_q == ST_RETRY);
  assign cur_op        = instr_ready ? instr_op : op_q;
  assign cur_addr      = instr_ready ? instr_addr : addr_q;
  assign win_full      = (win_cnt == ICW'(DEPTH));
  assign spill_full    = (scnt_q == SCW'(SPILL_DEPTH));
  assign total         = TW'(win_cnt) + TW'(scnt_q);
  assign spill_wr_addr = AW'(SPILL_BASE) + AW'(scnt_q);
  assign spill_rd_addr = spill_wr_addr - AW'(1);
  assign alu_op        = cur_op;

  always_comb begin
    state_d   = state_q;
    scnt_d    = scnt_q;
    unf_d     = 1'b0;
    ovf_d     = 1'b0;
    win_cmd   = W_HOLD;
    win_din   = alu_res;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = win_top;
    case (state_q)
      ST_IDLE, ST_RETRY: begin
        if (go) begin
          state_d = ST_IDLE;
          case (cur_op)
            OPC_PUSH: begin
              if (win_full && spill_full) begin
                ovf_d = 1'b1;
              end else if (win_full) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = spill_wr_addr;
                mem_wdata = win_bottom;
                win_cmd   = W_DROP;
                scnt_d    = scnt_q + 1'b1;
                state_d   = ST_FETCH;
              end else begin
                mem_req  = 1'b1;
                mem_addr = cur_addr;
                state_d  = ST_LOAD;
              end
            end
            OPC_POP: begin
              if (win_cnt != '0) begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_addr;
                win_cmd  = W_POP;
              end else if (scnt_q != '0) begin
                mem_req  = 1'b1;
                mem_addr = spill_rd_addr;
                state_d  = ST_REFILL;
              end else begin
                unf_d = 1'b1;
              end
            end
            OPC_ADD, OPC_SUB, OPC_MUL: begin
              if (win_cnt >= ICW'(2)) begin
                win_cmd = W_COMBINE;
              end else if (total >= TW'(2)) begin
                mem_req  = 1'b1;
                mem_addr = spill_rd_addr;
                state_d  = ST_REFILL;
              end else begin
                unf_d = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = addr_q;
        state_d  = ST_LOAD;
      end
      ST_LOAD: begin
        win_cmd = W_PUSH;
        win_din = mem_rdata;
        state_d = ST_IDLE;
      end
      ST_REFILL: begin
        win_cmd = W_APPEND;
        win_din = mem_rdata;
        scnt_d  = scnt_q - 1'b1;
        state_d = ST_RETRY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (go) begin
      op_q   <= cur_op;
      addr_q <= cur_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      unf_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      unf_q   <= unf_d;
      ovf_q   <= ovf_d;
    end
  end

  assign flag_underflow = unf_q;
  assign flag_overflow  = ovf_q;
  assign stack_depth    = total;

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stk_pkg::*;
#(
  parameter  int W           = 16,
  parameter  int AW          = 8,
  parameter  int DEPTH       = 4,
  parameter  int SPILL_DEPTH = 16,
  parameter  int SPILL_BASE  = 224,
  localparam int ICW         = $clog2(DEPTH + 1),
  localparam int TW          = $clog2(DEPTH + SPILL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [2:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          flag_underflow,
  output logic          flag_overflow,
  output logic [TW-1:0] stack_depth
);

  logic [1:0]     rst_sync_q;
  logic           rst_s;
  logic [ICW-1:0] win_cnt;
  logic [W-1:0]   win_top, win_second, win_bottom, win_din, alu_res;
  logic [2:0]     alu_op;
  win_cmd_e       win_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  stk_window #(.W(W), .DEPTH(DEPTH)) u_win (
    .clk    (clk),
    .rst_n  (rst_s),
    .cmd    (win_cmd),
    .din    (win_din),
    .top    (win_top),
    .second (win_second),
    .bottom (win_bottom),
    .cnt    (win_cnt)
  );

  stk_alu #(.W(W)) u_alu (
    .op     (alu_op),
    .top    (win_top),
    .second (win_second),
    .res    (alu_res)
  );

  stk_ctrl #(
    .W(W), .AW(AW), .DEPTH(DEPTH), .SPILL_DEPTH(SPILL_DEPTH), .SPILL_BASE(SPILL_BASE)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_s),
    .instr_valid    (instr_valid),
    .instr_ready    (instr_ready),
    .instr_op       (instr_op),
    .instr_addr     (instr_addr),
    .win_cnt        (win_cnt),
    .win_top        (win_top),
    .win_bottom     (win_bottom),
    .alu_res        (alu_res),
    .alu_op         (alu_op),
    .win_cmd        (win_cmd),
    .win_din        (win_din),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .flag_underflow (flag_underflow),
    .flag_overflow  (flag_overflow),
    .stack_depth    (stack_depth)
  );

endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk
  import stk_pkg::*;
#(
  parameter  int AW          = 8,
  parameter  int DEPTH       = 4,
  parameter  int SPILL_DEPTH = 16,
  localparam int ICW         = $clog2(DEPTH + 1),
  localparam int TW          = $clog2(DEPTH + SPILL_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_valid,
  input logic           instr_ready,
  input logic [2:0]     instr_op,
  input logic [AW-1:0]  instr_addr,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           flag_underflow,
  input logic [TW-1:0]  stack_depth,
  input logic [ICW-1:0] win_cnt
);

  logic take;
  assign take = instr_valid && instr_ready;

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr_op == OPC_PUSH && win_cnt < ICW'(DEPTH)) |=> ##1 (stack_depth == $past(stack_depth, 2) + 1'b1)); // R1

  AST_POP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr_op == OPC_POP && win_cnt != '0) |-> (mem_req && mem_we && mem_addr == instr_addr)); // R2

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_depth == $past(stack_depth)) || (stack_depth == $past(stack_depth) + 1'b1) ||
    (stack_depth + 1'b1 == $past(stack_depth))); // R3

  AST_WINDOW_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (instr_op == OPC_ADD || instr_op == OPC_SUB || instr_op == OPC_MUL) && win_cnt >= ICW'(2))
    |-> !mem_req); // R5

  AST_UNDERFLOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (stack_depth == $past(stack_depth))); // R8

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= TW'(DEPTH + SPILL_DEPTH)); // R9

endmodule

bind stack_exec_unit stk_exec_chk #(.AW(AW), .DEPTH(DEPTH), .SPILL_DEPTH(SPILL_DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_s),
  .instr_valid    (instr_valid),
  .instr_ready    (instr_ready),
  .instr_op       (instr_op),
  .instr_addr     (instr_addr),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .flag_underflow (flag_underflow),
  .stack_depth    (stack_depth),
  .win_cnt        (win_cnt)
);

// File: tb/sim_stack_exec_unit.sv
`timescale 1ns/1ps
module sim_stack_exec_unit;

  localparam int W = 16, AW = 8, DEPTH = 4, SPILL_DEPTH = 16, SPILL_BASE = 224;
  localparam int MAXT = DEPTH + SPILL_DEPTH;
  localparam int TW = $clog2(MAXT + 1);
  localparam logic [2:0] P_PUSH = 3'd0, P_POP = 3'd1, P_ADD = 3'd2, P_SUB = 3'd3, P_MUL = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic          instr_ready;
  logic [2:0]    instr_op = '0;
  logic [AW-1:0] instr_addr = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata;
  logic          flag_underflow, flag_overflow;
  logic [TW-1:0] stack_depth;

  always #5 clk = ~clk;

  stack_exec_unit #(
    .W(W), .AW(AW), .DEPTH(DEPTH), .SPILL_DEPTH(SPILL_DEPTH), .SPILL_BASE(SPILL_BASE)
  ) u0 (.*);

  // bench memory, synchronous, with a bench preload port
  logic [W-1:0]  ram [0:255];
  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_wa = '0;
  logic [W-1:0]  tb_wd = '0;
  int            n_req = 0, n_spill_wr = 0;

  always @(posedge clk) begin
    if (tb_we) ram[tb_wa] <= tb_wd;
    else if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (mem_req) n_req <= n_req + 1;
    if (mem_req && mem_we && mem_addr >= AW'(SPILL_BASE)) n_spill_wr <= n_spill_wr + 1;
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [W-1:0] shadow [0:255];
  logic [W-1:0] mstk [0:31];
  int md = 0;
  logic got_unf, got_ovf, rdy_after;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_alu(input logic [2:0] op, input logic [W-1:0] t, input logic [W-1:0] s);
    logic [2*W-1:0] p;
    p = t * s;
    case (op)
      P_SUB:   return t - s;
      P_MUL:   return p[W-1:0];
      default: return t + s;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    while (!instr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    got_unf = flag_underflow; got_ovf = flag_overflow; rdy_after = instr_ready;
    while (!instr_ready) @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input string tag);
    logic eu, eo, popchk;
    logic [W-1:0] val, t, s;
    eu = 0; eo = 0; popchk = 0; val = '0;
    case (op)
      P_PUSH: if (md == MAXT) eo = 1; else begin mstk[md] = shadow[a]; md++; end
      P_POP:  if (md == 0) eu = 1; else begin md--; val = mstk[md]; popchk = 1; shadow[a] = val; end
      P_ADD, P_SUB, P_MUL:
        if (md < 2) eu = 1;
        else begin t = mstk[md-1]; s = mstk[md-2]; md -= 2; mstk[md] = ref_alu(op, t, s); md++; end
      default: ;
    endcase
    issue(op, a);
    chk({tag, " R8 underflow flag"}, 32'(got_unf), 32'(eu));
    chk({tag, " R9 overflow flag"}, 32'(got_ovf), 32'(eo));
    chk({tag, " depth"}, 32'(stack_depth), 32'(md));
    if (popchk) chk({tag, " R2 popped word"}, 32'(ram[a]), 32'(val));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base_req, base_sp;
    logic [W-1:0] expv;
    void'($urandom(32'd20240611));
    // preload data region during reset
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_wa = AW'(i);
      tb_wd = (i == 20) ? 16'd9 : (i == 21) ? 16'd4 : (i == 30) ? 16'h0100 :
              (i == 31) ? 16'h0300 : W'($urandom);
      shadow[i] = tb_wd;
    end
    @(negedge clk); tb_we = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 ready", 32'(instr_ready), 1);
    chk("R11 depth", 32'(stack_depth), 0);
    chk("R11 flags", 32'({flag_underflow, flag_overflow}), 0);
    chk("R11 no request", 32'(mem_req), 0);

    // R8 underflow on empty and single-entry stacks
    do_op(P_ADD, 0, "R8 add empty");
    do_op(P_POP, 5, "R8 pop empty");
    do_op(P_PUSH, 7, "R1 push");
    chk("R12 ready low during push", 32'(rdy_after), 0);
    do_op(P_SUB, 0, "R8 sub one entry");
    do_op(P_POP, 100, "R2 pop");
    chk("R2 depth empty", 32'(stack_depth), 0);

    // R5 window arithmetic makes no memory access; R4 ordering with wrap
    do_op(P_PUSH, 20, "R1 push");
    do_op(P_PUSH, 21, "R1 push");
    base_req = n_req;
    do_op(P_SUB, 0, "R4 sub");
    chk("R5 no memory request", 32'(n_req - base_req), 0);
    chk("R12 ready stays high", 32'(rdy_after), 1);
    do_op(P_POP, 101, "R4 pop");
    chk("R4 top minus second", 32'(ram[101]), 32'(16'd65531));

    // R3 multiplication keeps low word
    do_op(P_PUSH, 30, "R1 push");
    do_op(P_PUSH, 31, "R1 push");
    do_op(P_MUL, 0, "R3 mult");
    do_op(P_POP, 102, "R3 pop");
    chk("R3 low product word", 32'(ram[102]), 0);

    // expression A = B + C*D - E + F + A
    expv = shadow[11] + shadow[12] * shadow[13] - shadow[14] + shadow[15] + shadow[10];
    do_op(P_PUSH, 14, "R1 E"); do_op(P_PUSH, 12, "R1 C"); do_op(P_PUSH, 13, "R1 D");
    do_op(P_MUL, 0, "R3 mult"); do_op(P_PUSH, 11, "R1 B"); do_op(P_ADD, 0, "R3 add");
    do_op(P_SUB, 0, "R4 sub"); do_op(P_PUSH, 15, "R1 F"); do_op(P_ADD, 0, "R3 add");
    do_op(P_PUSH, 10, "R1 A"); do_op(P_ADD, 0, "R3 add"); do_op(P_POP, 10, "R2 pop A");
    chk("R3 R4 expression result", 32'(ram[10]), 32'(expv));

    // R6 spill when deeper than the window, R7 refill on folding back
    base_sp = n_spill_wr;
    for (int i = 0; i < DEPTH + 3; i++) do_op(P_PUSH, AW'(40 + i), "R6 deep push");
    chk("R6 spill writes", 32'(n_spill_wr - base_sp), 3);
    expv = '0;
    for (int i = 0; i < DEPTH + 3; i++) expv = expv + shadow[40 + i];
    for (int i = 0; i < DEPTH + 2; i++) do_op(P_ADD, 0, "R7 refill add");
    do_op(P_POP, 103, "R7 pop");
    chk("R7 sum across spill", 32'(ram[103]), 32'(expv));

    // R9 overflow at full capacity, then drain in LIFO order
    for (int i = 0; i < MAXT; i++) do_op(P_PUSH, AW'(50 + i), "R6 fill");
    do_op(P_PUSH, 8'd90, "R9 push when full");
    chk("R9 depth held", 32'(stack_depth), MAXT);
    for (int i = 0; i < MAXT; i++) do_op(P_POP, AW'(130 + i), "R7 drain");

    // R10 no-effect opcodes
    do_op(P_PUSH, 3, "R1 push");
    base_req = n_req;
    for (int c = 5; c < 8; c++) do_op(3'(c), 8'd60, "R10 ignored op");
    chk("R10 no memory request", 32'(n_req - base_req), 0);
    do_op(P_POP, 104, "R10 value kept");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2: do_op(P_PUSH, AW'($urandom % 128), "R1 random push");
        3:       do_op(P_POP, AW'($urandom % 128), "R2 random pop");
        4:       do_op(P_ADD, 0, "R3 random add");
        5:       do_op(P_SUB, 0, "R4 random sub");
        6:       do_op(P_MUL, 0, "R3 random mult");
        default: do_op(3'(5 + $urandom % 3), 0, "R10 random ignored");
      endcase
    end
    while (md > 0) do_op(P_POP, AW'(64 + md), "R7 final drain");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule